// File: doc/BRIEF.md
# Compare/Capture Timer Channel

A single timer channel built around a 16-bit up-counter. The counter advances on a one-cycle count-enable pulse that an external prescaler supplies. The block reports the selected prescaler source back on `clk_sel`. Two compare registers each drive an output pin to a programmable level when a match occurs. The capture register takes a copy of the counter on a selectable edge of a synchronised capture input. Four sticky event flags (capture, compare A, compare B, wrap) combine with per-event enables to form four interrupt requests. Capture, compare A and compare B each have an acknowledge input that clears the flag.

Software reaches the registers over a word-wide internal register port. Writes take effect at the clock edge that samples `reg_wr`. Read data is combinational from `reg_addr`. `reg_rd` marks a real read access, which matters for flag clearing and for the capture-read interlock.

Register map (`reg_addr`):
- 0: control
- 1: status
- 2: counter
- 3: compare A
- 4: compare B
- 5: capture (read-only)

The 8-bit registers sit in the low byte.

Top module: `frt_channel`

## Requirements
- R1: After reset the counter is 0x0000, both compare registers read 0xFFFF, and the capture register reads 0x0000. Control and status read 0x00, and both output pins and all four interrupt requests are 0.
- R2: Each cycle with `cnt_tick` high, the counter increases by one and passes from 0xFFFF to 0x0000. A tick while the counter is 0xFFFF sets the wrap flag (status bit 4), unless a counter write happens in that cycle.
- R3: A compare match is raised in a cycle where `cnt_tick` is high and the counter equals the compare register. This is the last cycle of equality. At the next edge the match sets compare flag A (status bit 5) or compare flag B (status bit 6).
- R4: On a match, an output pin whose enable is set takes its level bit at the next edge. The enables are control bit 2 for A and bit 3 for B. The level bits are status bit 2 for A and bit 3 for B. Otherwise the pin holds its value.
- R5: With clear-on-A (status bit 0) set, a compare-A match loads 0x0000 into the counter instead of incrementing it. The counter therefore cycles through 0 to the compare value.
- R6: `cap_in` passes through a two-flop synchroniser. Status bit 1 selects the edge: 0 for falling, 1 for rising. On that edge the counter value is copied to the capture register and the capture flag (status bit 7) is set, even if the flag is already set. The other edge has no effect.
- R7: If a read of the capture register (`reg_rd` at address 5) takes place in the cycle the capture strobe would occur, the strobe is delayed by exactly one cycle.
- R8: Status bits 3:0 are freely writable. Writing 0 to a flag bit clears that flag only if a status read returned it as 1 since it was set. Writing 1 to a flag bit has no effect.
- R9: If a compare-A clear coincides with a counter write, the counter becomes 0x0000. If only an increment coincides with a counter write, the written value is loaded and no increment occurs.
- R10: A write to a compare register in a match cycle suppresses that register's match: no flag, no pin change, no clear.
- R11: Each interrupt request is its flag AND its enable. The enables are control bit 7 for capture, bit 6 for compare B, bit 5 for compare A and bit 4 for wrap. The priority order, highest first, is capture, compare A, compare B, wrap.
- R12: `ack_cap`, `ack_cmpa` and `ack_cmpb` clear their flag at the next edge without a prior read. A new event in the same cycle wins over the clear.
- R13: `clk_sel` always equals control bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | One-cycle count-enable pulse from the prescaler |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read access marker |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| cap_in | input | 1 | Asynchronous capture input |
| ack_cap | input | 1 | Capture flag acknowledge |
| ack_cmpa | input | 1 | Compare A flag acknowledge |
| ack_cmpb | input | 1 | Compare B flag acknowledge |
| out_a | output | 1 | Compare A output pin |
| out_b | output | 1 | Compare B output pin |
| irq_cap | output | 1 | Capture interrupt request |
| irq_cmpa | output | 1 | Compare A interrupt request |
| irq_cmpb | output | 1 | Compare B interrupt request |
| irq_ovf | output | 1 | Wrap interrupt request |
| clk_sel | output | 2 | Prescaler source select |

## Verification
The embedded properties watch several behaviours on every cycle:
- a match sets its flag;
- a pin holds outside a match;
- a counter write lands unless a clear overrides it;
- a flag stays set until acknowledged or written;
- the capture register holds the counter value of the strobe cycle;
- the wrap flag follows a tick at 0xFFFF.

Only the bench scenarios can show the exact cycle in which a match fires relative to the count pulses, and the counter period under clear-on-A across a sweep of compare values. The same holds for the read-before-clear rule on flags, the one-cycle capture delay under a concurrent capture read, and edge selection through the synchroniser.

// File: rtl/frt_channel.sv
module frt_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_tick,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  input  logic          cap_in,
  input  logic          ack_cap,
  input  logic          ack_cmpa,
  input  logic          ack_cmpb,
  output logic          out_a,
  output logic          out_b,
  output logic          irq_cap,
  output logic          irq_cmpa,
  output logic          irq_cmpb,
  output logic          irq_ovf,
  output logic [1:0]    clk_sel
);

  localparam logic [2:0] AD_CTRL = 3'd0;
  localparam logic [2:0] AD_STAT = 3'd1;
  localparam logic [2:0] AD_CNT  = 3'd2;
  localparam logic [2:0] AD_CMPA = 3'd3;
  localparam logic [2:0] AD_CMPB = 3'd4;
  localparam logic [2:0] AD_CAP  = 3'd5;
  localparam logic [CW-1:0] ALL1 = {CW{1'b1}};
  localparam int FI_OVF = 0, FI_A = 1, FI_B = 2, FI_CAP = 3;

  logic [7:0]    ctrl;
  logic [3:0]    cfg;
  logic [3:0]    flg, flg_nx, armed, set_v, ack_v, sw_clr;
  logic [CW-1:0] cnt, cmp_a, cmp_b, cap_r;
  logic          s1, s2, s3, pend;

  logic wr_ctrl, wr_stat, wr_cnt, wr_cmpa, wr_cmpb, rd_stat, rd_cap;
  logic hit_a, hit_b, clr_evt, wrap, cap_edge, cap_stb;

  assign wr_ctrl = reg_wr && reg_addr == AD_CTRL;
  assign wr_stat = reg_wr && reg_addr == AD_STAT;
  assign wr_cnt  = reg_wr && reg_addr == AD_CNT;
  assign wr_cmpa = reg_wr && reg_addr == AD_CMPA;
  assign wr_cmpb = reg_wr && reg_addr == AD_CMPB;
  assign rd_stat = reg_rd && reg_addr == AD_STAT;
  assign rd_cap  = reg_rd && reg_addr == AD_CAP;

  assign hit_a   = cnt_tick && cnt == cmp_a && !wr_cmpa;
  assign hit_b   = cnt_tick && cnt == cmp_b && !wr_cmpb;
  assign clr_evt = hit_a && cfg[0];
  assign wrap    = cnt_tick && cnt == ALL1 && !wr_cnt;

  assign cap_edge = cfg[1] ? (s2 && !s3) : (!s2 && s3);
  assign cap_stb  = (cap_edge && !rd_cap) || pend;

  assign set_v  = {cap_stb, hit_b, hit_a, wrap};
  assign ack_v  = {ack_cap, ack_cmpb, ack_cmpa, 1'b0};
  assign sw_clr = {4{wr_stat}} & ~reg_wdata[7:4] & armed;
  assign flg_nx = set_v | (flg & ~sw_clr & ~ack_v);

  assign irq_cap  = flg[FI_CAP] & ctrl[7];
  assign irq_cmpb = flg[FI_B]   & ctrl[6];
  assign irq_cmpa = flg[FI_A]   & ctrl[5];
  assign irq_ovf  = flg[FI_OVF] & ctrl[4];
  assign clk_sel  = ctrl[1:0];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AD_CTRL: reg_rdata[7:0] = ctrl;
      AD_STAT: reg_rdata[7:0] = {flg, cfg};
      AD_CNT:  reg_rdata = cnt;
      AD_CMPA: reg_rdata = cmp_a;
      AD_CMPB: reg_rdata = cmp_b;
      AD_CAP:  reg_rdata = cap_r;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (clr_evt) cnt <= '0;
    else if (wr_cnt) cnt <= reg_wdata;
    else if (cnt_tick) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      cfg   <= '0;
      cmp_a <= ALL1;
      cmp_b <= ALL1;
    end else begin
      if (wr_ctrl) ctrl <= reg_wdata[7:0];
      if (wr_stat) cfg <= reg_wdata[3:0];
      if (wr_cmpa) cmp_a <= reg_wdata;
      if (wr_cmpb) cmp_b <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg   <= '0;
      armed <= '0;
    end else begin
      flg <= flg_nx;
      for (int i = 0; i < 4; i++) begin
        if (!flg_nx[i]) armed[i] <= 1'b0;
        else if (rd_stat && flg[i]) armed[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_a <= 1'b0;
      out_b <= 1'b0;
    end else begin
      if (hit_a && ctrl[2]) out_a <= cfg[2];
      if (hit_b && ctrl[3]) out_b <= cfg[3];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {s1, s2, s3} <= '0;
      pend  <= 1'b0;
      cap_r <= '0;
    end else begin
      s1   <= cap_in;
      s2   <= s1;
      s3   <= s2;
      pend <= cap_edge && rd_cap;
      if (cap_stb) cap_r <= cnt;
    end
  end

  p_match_flag_r3: assert property (@(posedge clk) disable iff (rst)
    hit_a |=> flg[FI_A]);
  p_pin_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !hit_a |=> $stable(out_a));
  p_clear_a_r5: assert property (@(posedge clk) disable iff (rst)
    clr_evt |=> cnt == '0);
  p_wrap_flag_r2: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flg[FI_OVF]);
  p_capture_copy_r6: assert property (@(posedge clk) disable iff (rst)
    cap_stb |=> cap_r == $past(cnt));
  p_write_lands_r9: assert property (@(posedge clk) disable iff (rst)
    wr_cnt && !clr_evt |=> cnt == $past(reg_wdata));
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    flg[FI_A] && !ack_cmpa && !wr_stat |=> flg[FI_A]);
  p_ack_clears_r12: assert property (@(posedge clk) disable iff (rst)
    ack_cmpb && !hit_b |=> !flg[FI_B]);

endmodule

// File: tb/test_frt_channel.sv
`timescale 1ns/1ps
module test_frt_channel;
  logic clk = 0, rst = 1, cnt_tick = 0, reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic cap_in = 0, ack_cap = 0, ack_cmpa = 0, ack_cmpb = 0;
  logic out_a, out_b, irq_cap, irq_cmpa, irq_cmpb, irq_ovf;
  logic [1:0] clk_sel;
  int checks = 0, errors = 0;
  logic [15:0] v, x, c0;

  frt_channel i_frt_channel (.clk, .rst, .cnt_tick, .reg_wr, .reg_rd, .reg_addr,
    .reg_wdata, .reg_rdata, .cap_in, .ack_cap, .ack_cmpa, .ack_cmpb, .out_a,
    .out_b, .irq_cap, .irq_cmpa, .irq_cmpb, .irq_ovf, .clk_sel);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask
  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask
  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata; reg_rd = 1; cyc(); reg_rd = 0;
  endtask
  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic tk = 0);
    reg_addr = a; reg_wdata = d; reg_wr = 1; cnt_tick = tk; cyc();
    reg_wr = 0; cnt_tick = 0;
  endtask
  task automatic ticks(input int n);
    cnt_tick = 1; repeat (n) cyc(); cnt_tick = 0;
  endtask
  task automatic clearf(input logic [3:0] cfg);
    logic [15:0] t;
    rd(3'd1, t); wr(3'd1, {12'h0, cfg});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cyc();
    // R1 reset state
    peek(2, v); chk("R1 counter", v, 16'h0000);
    peek(3, v); chk("R1 cmpA", v, 16'hFFFF);
    peek(4, v); chk("R1 cmpB", v, 16'hFFFF);
    peek(5, v); chk("R1 capture", v, 16'h0000);
    peek(0, v); chk("R1 ctrl", v, 0);
    peek(1, v); chk("R1 status", v, 0);
    chk("R1 pins/irqs", {out_a, out_b, irq_cap, irq_cmpa, irq_cmpb, irq_ovf}, 0);

    // R13 clock select follows control bits 1:0
    wr(0, 16'h0003); chk("R13 clk_sel", clk_sel, 2'd3);
    wr(0, 16'h0002); chk("R13 clk_sel", clk_sel, 2'd2);
    wr(0, 16'h0000);

    // R2 increment sweep
    foreach (c0[i]) if (i < 3) begin
      logic [15:0] base;
      base = (i == 0) ? 16'h0000 : (i == 1) ? 16'h00FF : 16'hFFF0;
      wr(2, base); ticks(7 + i);
      peek(2, v); chk("R2 increment", v, base + 16'(7 + i));
    end
    clearf(4'h0);
    wr(2, 16'hFFFE); ticks(1);
    peek(1, v); chk("R2 no wrap yet", v[4], 0);
    ticks(1);
    peek(2, v); chk("R2 wrap value", v, 16'h0000);
    peek(1, v); chk("R2 wrap flag", v[4], 1);

    // R3 R4 match timing and pins
    clearf(4'hC);
    wr(0, 16'h0004);
    wr(3, 16'd5); wr(4, 16'd3); wr(2, 16'd0);
    ticks(5);
    chk("R4 pin A before match", out_a, 0);
    peek(1, v); chk("R3 flag A not yet", v[5], 0);
    chk("R3 flag B set", v[6], 1);
    chk("R4 pin B disabled", out_b, 0);
    ticks(1);
    chk("R4 pin A level 1", out_a, 1);
    peek(1, v); chk("R3 flag A set", v[5], 1);
    peek(2, v); chk("R3 counter after match", v, 16'd6);
    wr(1, 16'h00F8); wr(2, 16'd5); ticks(1);
    chk("R4 pin A level 0", out_a, 0);

    // R8 read-before-clear
    wr(1, 16'h0008);
    peek(1, v); chk("R8 unread flag kept", v[5], 1);
    chk("R8 cfg writable", v[3:0], 4'h8);
    rd(1, v); wr(1, 16'h00F8);
    peek(1, v); chk("R8 write one ignored", v[5], 1);
    wr(1, 16'h0008);
    peek(1, v); chk("R8 read then zero clears", v[5], 0);

    // R11 R12 interrupts and acknowledge
    wr(0, 16'h0020); wr(2, 16'd5); ticks(1);
    chk("R11 irq A", irq_cmpa, 1);
    chk("R11 irq B masked", irq_cmpb, 0);
    ack_cmpa = 1; cyc(); ack_cmpa = 0;
    peek(1, v); chk("R12 ack clears A", v[5], 0);
    chk("R12 irq A dropped", irq_cmpa, 0);
    wr(0, 16'h0010); wr(2, 16'hFFFF); ticks(1);
    chk("R11 irq wrap", irq_ovf, 1);
    wr(0, 16'h0000);

    // R9 contention
    clearf(4'h1);
    wr(3, 16'd10); wr(2, 16'd10); wr(2, 16'h1234, 1);
    peek(2, v); chk("R9 clear beats write", v, 16'h0000);
    wr(1, 16'h00F0); wr(2, 16'h1234, 1);
    peek(2, v); chk("R9 write beats increment", v, 16'h1234);

    // R5 clear-on-A period sweep
    wr(1, 16'h00F1);
    for (int k = 0; k < 6; k++) begin
      wr(3, 16'(k)); wr(2, 16'd0); ticks(2 * k + 3);
      peek(2, v); chk("R5 period", v, 16'((2 * k + 3) % (k + 1)));
    end

    // R10 compare write suppresses match
    clearf(4'h0);
    wr(4, 16'd7); wr(2, 16'd7); wr(4, 16'd7, 1);
    peek(1, v); chk("R10 match suppressed", v[6], 0);
    peek(2, v); chk("R10 counter advanced", v, 16'd8);
    wr(2, 16'd7); ticks(1);
    peek(1, v); chk("R10 match without write", v[6], 1);

    // R6 rising capture
    clearf(4'h2);
    cnt_tick = 1; cap_in = 1; cyc();
    peek(2, x); cyc(); cyc(); cnt_tick = 0;
    peek(5, v); chk("R6 rising capture", v, x + 16'd1);
    c0 = v;
    peek(1, v); chk("R6 capture flag", v[7], 1);
    cnt_tick = 1; cap_in = 0; repeat (5) cyc(); cnt_tick = 0;
    peek(5, v); chk("R6 falling ignored when rising", v, c0);
    wr(1, 16'h00F0);
    cnt_tick = 1; cap_in = 1; repeat (5) cyc(); cnt_tick = 0;
    peek(5, v); chk("R6 rising ignored when falling", v, c0);

    // R7 falling capture delayed by capture read; flag already set
    cnt_tick = 1; cap_in = 0; cyc();
    peek(2, x); cyc();
    reg_addr = 5; reg_rd = 1; cyc(); reg_rd = 0;
    peek(5, v); chk("R7 strobe held back", v, c0);
    cyc(); cnt_tick = 0;
    peek(5, v); chk("R7 delayed capture value", v, x + 16'd2);
    peek(1, v); chk("R6 flag still set", v[7], 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule